// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address sequence for a four-beat memory burst. A starting address is captured when either of two address strobes is accepted. On every later clock edge where advance is asserted, an internal beat count steps by one, and the two low address bits follow either an interleaved order or a linear order. The order is chosen by a mode input that is held static. The upper address bits stay at the value that was loaded for the whole burst. When the burst passes its fourth beat it returns to the beat it started on. A flag marks the final beat.

The two strobes differ in one way. The controller strobe is always honoured. The processor strobe counts only while the chip-enable input is high. A load always wins over an advance that comes in the same cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, and after it, until the first load, `addrOut` is 0 and `lastBeat` is 0.
- R2: When `loadCtrlN` is 0 at a rising edge, whatever the state of `chipEn`, `addrOut` equals the sampled `addrIn` after that edge and the beat count returns to 0.
- R3: When `loadProcN` is 0 at a rising edge, it loads `addrIn` only if `chipEn` is 1. With `chipEn` at 0 and no other load, the edge leaves the upper address bits unchanged.
- R4: With no load accepted, `advN` at 0 steps the beat count by one. `advN` at 1 holds the count.
- R5: With `orderIlv` at 1, the low two bits of `addrOut` equal the loaded start bits XOR the beat count (0,1,2,3).
- R6: With `orderIlv` at 0, the low two bits equal the loaded start bits plus the beat count, modulo 4.
- R7: An advance taken on beat 3 returns the beat count to 0, so the low bits show the starting beat again.
- R8: The upper bits `addrOut[ADDR_W-1:2]` change only on an accepted load.
- R9: `lastBeat` is 1 exactly when the beat count is 3.
- R10: When a load and an advance arrive in the same cycle, the load is taken and the beat count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadCtrlN | input | 1 | Controller address strobe, active low, not gated |
| loadProcN | input | 1 | Processor address strobe, active low, gated by chipEn |
| chipEn | input | 1 | Chip enable that qualifies loadProcN |
| advN | input | 1 | Burst advance, active low |
| orderIlv | input | 1 | Static order select: 1 interleaved, 0 linear |
| addrIn | input | ADDR_W | External starting address |
| addrOut | output | ADDR_W | Current burst address |
| lastBeat | output | 1 | High on the fourth beat of a burst |

## Verification
The bench aims at start values other than zero in both orders. A linear counter running in interleaved mode, or the reverse, gives the wrong middle beats for start values 1 and 3. It runs bursts longer than four advances to catch a counter that stops at 3 or that wraps to zero instead of to the start. It fires a processor strobe while the chip is disabled, and a load together with an advance in the same cycle. A design that ignores the enable would pick up a new upper address. A design that gives priority to the advance would leave the beat count at a value other than zero.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic load;  // capture a new start address, clear beat count
    logic step;  // advance beat count by one
  } burstCtl_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic      loadCtrlN,
  input  logic      loadProcN,
  input  logic      chipEn,
  input  logic      advN,
  output burstCtl_t ctl
);

  logic procAccepted;
  logic anyLoad;

  // Processor strobe only counts while the chip is enabled
  assign procAccepted = ~loadProcN & chipEn;
  assign anyLoad      = ~loadCtrlN | procAccepted;

  always_comb begin
    ctl      = '0;
    ctl.load = anyLoad;
    // load takes precedence over advance
    ctl.step = ~anyLoad & ~advN;
  end

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstCtl_t         ctl,
  input  logic              orderIlv,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              lastBeat
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [UPPER_W-1:0] upperQ;
  logic [BEAT_W-1:0]  startQ;
  logic [BEAT_W-1:0]  beatQ;
  logic [BEAT_W-1:0]  ilvLow;
  logic [BEAT_W-1:0]  linLow;
  logic [BEAT_W-1:0]  lowSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ <= '0;
      startQ <= '0;
      beatQ  <= '0;
    end else if (ctl.load) begin
      upperQ <= addrIn[ADDR_W-1:BEAT_W];
      startQ <= addrIn[BEAT_W-1:0];
      beatQ  <= '0;
    end else if (ctl.step) begin
      beatQ  <= beatQ + 1'b1;  // natural wrap back to the starting beat
    end
  end

  // Interleaved order: per-bit exclusive-or of start and beat count
  for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
    assign ilvLow[i] = startQ[i] ^ beatQ[i];
  end

  // Linear order: modular sum, carry out discarded
  assign linLow = startQ + beatQ;

  assign lowSel   = orderIlv ? ilvLow : linLow;
  assign addrOut  = {upperQ, lowSel};
  assign lastBeat = &beatQ;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadCtrlN,
  input  logic              loadProcN,
  input  logic              chipEn,
  input  logic              advN,
  input  logic              orderIlv,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              lastBeat
);

  localparam int BEAT_W = 2;

  burstCtl_t ctl;

  burst_ctrl u_ctrl (
    .loadCtrlN (loadCtrlN),
    .loadProcN (loadProcN),
    .chipEn    (chipEn),
    .advN      (advN),
    .ctl       (ctl)
  );

  burst_datapath #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .orderIlv (orderIlv),
    .addrIn   (addrIn),
    .addrOut  (addrOut),
    .lastBeat (lastBeat)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadCtrlN,
  input logic              loadProcN,
  input logic              chipEn,
  input logic              advN,
  input logic              orderIlv,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] addrOut,
  input logic              lastBeat
);

  logic loadSeen;
  logic noLoad;

  assign loadSeen = ~loadCtrlN | (~loadProcN & chipEn);
  assign noLoad   = ~loadSeen;

  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |-> (addrOut == '0 && !lastBeat)); // R1

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !loadCtrlN |=> (addrOut == $past(addrIn) && !lastBeat)); // R2

  AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (loadCtrlN && !loadProcN && !chipEn) |=> $stable(addrOut[ADDR_W-1:2])); // R3

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    (noLoad && advN) |=> $stable(lastBeat)); // R4

  AST_WRAP_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (noLoad && !advN && lastBeat) |=> !lastBeat); // R7

  AST_UPPER_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    noLoad |=> $stable(addrOut[ADDR_W-1:2])); // R8

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (loadSeen && !advN) |=> (addrOut == $past(addrIn) && !lastBeat)); // R10

  // orderIlv is static; referenced so every port is in use
  AST_MODE_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(orderIlv)); // R5

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loadCtrlN (loadCtrlN),
  .loadProcN (loadProcN),
  .chipEn    (chipEn),
  .advN      (advN),
  .orderIlv  (orderIlv),
  .addrIn    (addrIn),
  .addrOut   (addrOut),
  .lastBeat  (lastBeat)
);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadCtrlN = 1'b1;
  logic          loadProcN = 1'b1;
  logic          chipEn = 1'b0;
  logic          advN = 1'b1;
  logic          orderIlv = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] addrOut;
  logic          lastBeat;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string curReq = "R1";

  // reference model state
  int mUpper = 0;
  int mStart = 0;
  int mBeat  = 0;

  always #2 clk = ~clk;  // 250 MHz

  burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
    .clk(clk), .rstN(rstN), .loadCtrlN(loadCtrlN), .loadProcN(loadProcN),
    .chipEn(chipEn), .advN(advN), .orderIlv(orderIlv), .addrIn(addrIn),
    .addrOut(addrOut), .lastBeat(lastBeat)
  );

  // behavioural model, updated on the same edge as the design
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mUpper = 0; mStart = 0; mBeat = 0;
    end else begin
      bit ld;
      ld = (loadCtrlN == 1'b0) || (loadProcN == 1'b0 && chipEn == 1'b1);
      if (ld) begin
        mUpper = int'(addrIn) >> 2;
        mStart = int'(addrIn) & 3;
        mBeat  = 0;
      end else if (advN == 1'b0) begin
        mBeat = (mBeat + 1) % 4;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      int expLow;
      int gotLow;
      int gotUp;
      expLow = orderIlv ? (mStart ^ mBeat) : ((mStart + mBeat) % 4);
      gotLow = int'(addrOut[1:0]);
      gotUp  = int'(addrOut[AW-1:2]);
      checks++;
      if (gotLow != expLow) begin
        errors++;
        $display("FAIL %s low bits got %0d exp %0d (t=%0t)", curReq, gotLow, expLow, $time);
      end
      checks++;
      if (gotUp != mUpper) begin
        errors++;
        $display("FAIL %s upper bits (R8) got %0h exp %0h (t=%0t)",
                 (curReq == "R1") ? "R1" : "R8", gotUp, mUpper, $time);
      end
      checks++;
      if (lastBeat !== (mBeat == 3)) begin
        errors++;
        $display("FAIL R9 lastBeat got %0b exp %0b (t=%0t)", lastBeat, (mBeat == 3), $time);
      end
    end
  end

  task automatic drive(input logic lc, input logic lp, input logic ce,
                       input logic adv, input logic ilv, input logic [AW-1:0] a);
    @(negedge clk);
    #1;
    loadCtrlN = lc; loadProcN = lp; chipEn = ce; advN = adv; orderIlv = ilv; addrIn = a;
  endtask

  task automatic advanceN(input int n, input logic ilv);
    for (int i = 0; i < n; i++) drive(1, 1, 0, 0, ilv, 16'hFFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with strobes active that must not matter
    curReq = "R1";
    drive(0, 0, 1, 0, 1, 16'hBEEF);
    repeat (3) @(negedge clk);
    drive(1, 1, 0, 1, 1, 16'h0000);
    #1 rstN = 1'b1;
    repeat (2) drive(1, 1, 0, 1, 1, 16'h0000);

    // R2: controller strobe with chip disabled, interleaved order, start 2
    curReq = "R2";
    drive(0, 1, 0, 1, 1, 16'hA5F2);
    drive(1, 1, 0, 1, 1, 16'h0000);
    // R5 and R7: interleaved burst past its end
    curReq = "R5";
    advanceN(3, 1);
    curReq = "R7";
    advanceN(3, 1);

    // R3: processor strobe ignored while disabled, accepted while enabled
    curReq = "R3";
    drive(1, 0, 0, 1, 1, 16'h1234);
    drive(1, 1, 0, 1, 1, 16'h0000);
    drive(1, 0, 1, 1, 1, 16'h4321);
    drive(1, 1, 0, 1, 1, 16'h0000);

    // R4: alternate hold and advance
    curReq = "R4";
    drive(1, 1, 0, 0, 1, 16'h0000);
    drive(1, 1, 0, 1, 1, 16'h0000);
    drive(1, 1, 0, 1, 1, 16'h0000);
    drive(1, 1, 0, 0, 1, 16'h0000);
    drive(1, 1, 0, 1, 1, 16'h0000);

    // R6: switch to linear order together with a load, start 3
    curReq = "R6";
    drive(0, 1, 0, 1, 0, 16'h7003);
    advanceN(3, 0);
    curReq = "R7";
    advanceN(2, 0);
    curReq = "R6";
    drive(0, 1, 0, 1, 0, 16'h0C01);
    advanceN(5, 0);

    // R10: load arriving together with advance
    curReq = "R10";
    drive(1, 0, 1, 0, 0, 16'h5552);
    drive(0, 1, 0, 0, 0, 16'h0DD1);
    drive(1, 1, 0, 1, 0, 16'h0000);

    // mixed traffic in each order
    for (int m = 0; m < 2; m++) begin
      logic ilv;
      ilv = (m == 0);
      curReq = ilv ? "R5" : "R6";
      drive(0, 1, 0, 1, ilv, 16'(($urandom % 65536)));
      for (int k = 0; k < 150; k++) begin
        int r;
        r = $urandom % 16;
        if (r == 0)
          drive(0, 1, 0, ($urandom % 2), ilv, 16'(($urandom % 65536)));
        else if (r == 1)
          drive(1, 0, ($urandom % 2), ($urandom % 2), ilv, 16'(($urandom % 65536)));
        else
          drive(1, 1, ($urandom % 2), ($urandom % 3 == 0), ilv, 16'(($urandom % 65536)));
      end
      drive(1, 1, 0, 1, ilv, 16'h0000);
      drive(1, 1, 0, 1, ilv, 16'h0000);
    end

    @(negedge clk);
    #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule